// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block sits behind the transaction decoder of a two-wire serial memory. It owns one nonvolatile control register. The decoder gives it one-cycle events: transfer start, a completed 16-bit word address, each received data byte, and the stop condition. For every data byte the block decides whether to acknowledge it. It also decides whether the transfer, once its stop arrives, does one of these things:

- sets a write-enable latch;
- commits a new register value and launches the modeled nonvolatile store;
- starts one of the two supply-threshold programming sequences.

A register update takes three transfers to the register address, each carrying one data byte, and bits [2:1] of that byte select the step. The pattern 01 arms the first latch (`wel`). The pattern 11 arms the second latch (`rwel`), but only once `wel` is set. The pattern 00 is accepted only with both latches armed, and the whole byte then becomes the new register value. A completed commit drops `rwel`, so the next change needs the second step again.

Register bit 7 is a lock enable: with it set and the `wp_pin` input high, the register refuses writes. Bits [5:4] carry the watchdog period selection that the store saves. A commit or threshold sequence keeps `busy` high for a parameterized write time, and the block refuses new operations during that time.

Top module: `ctrl_reg_guard`

## Requirements
- R1: After reset `ctrl_q` equals `INIT_CTRL` (default 00h), `wel`, `rwel` and `busy` are low, and no pulse output is high.
- R2: A byte with bits [2:1]=01 written to `REG_ADDR` (FFFFh) is acknowledged, and `wel` is high in the cycle after the stop. `ctrl_q` is unchanged.
- R3: A byte with bits [2:1]=11 written to `REG_ADDR` is acknowledged only while `wel` is high, and then sets `rwel` after the stop. Without `wel` it is not acknowledged and `rwel` stays low.
- R4: With `wel` and `rwel` high, a byte with bits [2:1]=00 to `REG_ADDR` is acknowledged. In the cycle after the stop, `ctrl_q` holds that byte, `nv_store` pulses for one cycle, `rwel` is low and `wel` stays high. Without both latches the byte is not acknowledged and `ctrl_q` is unchanged.
- R5: Only the first data byte of a transfer can be acknowledged. Later bytes report `ack`=0 and do not replace the value committed.
- R6: A transfer that stops before any data byte, or that a new start abandons, changes neither `ctrl_q` nor the latches.
- R7: While `wp_pin` is high and `ctrl_q[7]` is 1, bytes to `REG_ADDR` are not acknowledged and no latch or register changes.
- R8: `busy` is high for exactly `WR_CYCLES` cycles from the cycle after an accepted commit or threshold stop. While it is high, every data byte is not acknowledged.
- R9: With `wel` and `hv_prog` high, byte 00h to `SET_ADDR` (0001h) is acknowledged and pulses `trip_set` after the stop. Byte 00h to `CLR_ADDR` (0003h) is acknowledged and pulses `trip_reset`. With `hv_prog` low, neither byte is acknowledged and no pulse occurs.
- R10: While `sys_rst` is high, no data byte is acknowledged, a stop has no effect, and an open transfer is dropped.
- R11: Every data byte produces `ack_vld` one cycle later. Bytes to any other address report `ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_rst | input | 1 | System reset active; blocks new operations |
| wp_pin | input | 1 | Write-protect pin level |
| hv_prog | input | 1 | High programming voltage present on the protect pin |
| bus_start | input | 1 | Start condition event |
| bus_addr_vld | input | 1 | Word address complete event |
| bus_addr | input | 16 | Word address |
| bus_data_vld | input | 1 | Data byte received event |
| bus_data | input | 8 | Data byte |
| bus_stop | input | 1 | Stop condition event |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge the byte |
| ctrl_q | output | 8 | Current control register value |
| wel | output | 1 | First write-enable latch |
| rwel | output | 1 | Second write-enable latch |
| busy | output | 1 | Nonvolatile write cycle in progress |
| nv_store | output | 1 | One-cycle pulse: register store launched |
| trip_set | output | 1 | One-cycle pulse: threshold set sequence launched |
| trip_reset | output | 1 | One-cycle pulse: threshold reset sequence launched |

## Verification
Every cycle, the assertions check these rules:

- the three launch pulses never coincide;
- a store launches only when the block was idle and not in system reset, and it leaves `busy` high and `rwel` low;
- `rwel` never rises without `wel`;
- `ctrl_q` changes only together with a store pulse;
- an acknowledge never follows a system-reset cycle;
- the threshold pulses never appear without `wel`.

Only the bench scenarios can show the rest:

- the exact step patterns that arm each latch;
- that the first byte of a transfer wins over later ones;
- that abandoned transfers have no effect;
- the length of the busy window;
- the pin lock taking effect once bit 7 has been stored.

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard #(
  parameter int          WR_CYCLES = 200,
  parameter logic [15:0] REG_ADDR  = 16'hFFFF,
  parameter logic [15:0] SET_ADDR  = 16'h0001,
  parameter logic [15:0] CLR_ADDR  = 16'h0003,
  parameter logic [7:0]  INIT_CTRL = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_rst,
  input  logic        wp_pin,
  input  logic        hv_prog,
  input  logic        bus_start,
  input  logic        bus_addr_vld,
  input  logic [15:0] bus_addr,
  input  logic        bus_data_vld,
  input  logic [7:0]  bus_data,
  input  logic        bus_stop,
  output logic        ack_vld,
  output logic        ack,
  output logic [7:0]  ctrl_q,
  output logic        wel,
  output logic        rwel,
  output logic        busy,
  output logic        nv_store,
  output logic        trip_set,
  output logic        trip_reset
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {K_NONE, K_WEL, K_RWEL, K_COMMIT, K_TSET, K_TCLR} kind_t;

  logic [15:0] addr_q;
  logic        have_addr, seen_data;
  kind_t       kind_q, kind_d;
  logic [7:0]  data_q;
  logic [CW-1:0] cnt;

  wire locked   = wp_pin && ctrl_q[7];
  wire first    = have_addr && !seen_data;
  wire reg_kind = (kind_q == K_WEL) || (kind_q == K_RWEL) || (kind_q == K_COMMIT);
  wire go       = bus_stop && !sys_rst && !busy && (kind_q != K_NONE) && !(reg_kind && locked);

  assign busy = (cnt != '0);

  always_comb begin
    kind_d = K_NONE;
    if (first && !sys_rst && !busy) begin
      if (addr_q == REG_ADDR) begin
        if (!locked) begin
          case (bus_data[2:1])
            2'b01:   kind_d = K_WEL;
            2'b11:   if (wel) kind_d = K_RWEL;
            2'b00:   if (wel && rwel) kind_d = K_COMMIT;
            default: kind_d = K_NONE;
          endcase
        end
      end else if (wel && hv_prog && bus_data == 8'h00) begin
        if (addr_q == SET_ADDR)      kind_d = K_TSET;
        else if (addr_q == CLR_ADDR) kind_d = K_TCLR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      have_addr  <= 1'b0;
      seen_data  <= 1'b0;
      kind_q     <= K_NONE;
      data_q     <= '0;
      ctrl_q     <= INIT_CTRL;
      wel        <= 1'b0;
      rwel       <= 1'b0;
      cnt        <= '0;
      ack_vld    <= 1'b0;
      ack        <= 1'b0;
      nv_store   <= 1'b0;
      trip_set   <= 1'b0;
      trip_reset <= 1'b0;
    end else begin
      ack_vld    <= bus_data_vld;
      ack        <= bus_data_vld && (kind_d != K_NONE);
      nv_store   <= 1'b0;
      trip_set   <= 1'b0;
      trip_reset <= 1'b0;
      if (busy) cnt <= cnt - CW'(1);

      if (sys_rst || bus_start || bus_stop) begin
        have_addr <= 1'b0;
        seen_data <= 1'b0;
        kind_q    <= K_NONE;
      end else if (bus_addr_vld) begin
        addr_q    <= bus_addr;
        have_addr <= 1'b1;
        seen_data <= 1'b0;
        kind_q    <= K_NONE;
      end else if (bus_data_vld) begin
        seen_data <= 1'b1;
        if (first) begin
          kind_q <= kind_d;
          data_q <= bus_data;
        end
      end

      if (go) begin
        case (kind_q)
          K_WEL:  wel  <= 1'b1;
          K_RWEL: rwel <= 1'b1;
          K_COMMIT: begin
            ctrl_q   <= data_q;
            rwel     <= 1'b0;
            nv_store <= 1'b1;
            cnt      <= CW'(WR_CYCLES);
          end
          K_TSET: begin
            trip_set <= 1'b1;
            cnt      <= CW'(WR_CYCLES);
          end
          K_TCLR: begin
            trip_reset <= 1'b1;
            cnt        <= CW'(WR_CYCLES);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctrl_reg_guard_chk.sv
module ctrl_reg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       ack,
  input logic [7:0] ctrl_q,
  input logic       wel,
  input logic       rwel,
  input logic       busy,
  input logic       nv_store,
  input logic       trip_set,
  input logic       trip_reset
);
  assert_one_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({nv_store, trip_set, trip_reset}) <= 1);

  assert_store_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store |-> !$past(busy) && !$past(sys_rst));

  assert_store_effects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_store |-> busy && !rwel && wel);

  assert_ctrl_only_on_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> nv_store);

  assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> wel);

  assert_no_ack_in_sysrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(sys_rst));

  assert_trip_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_set || trip_reset) |-> wel && busy);
endmodule

bind ctrl_reg_guard ctrl_reg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .ack(ack), .ctrl_q(ctrl_q),
  .wel(wel), .rwel(rwel), .busy(busy), .nv_store(nv_store),
  .trip_set(trip_set), .trip_reset(trip_reset)
);

// File: tb/test_ctrl_reg_guard.sv
module test_ctrl_reg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WR = 8;

  logic clk = 0, rst_n = 0, sys_rst = 0, wp_pin = 0, hv_prog = 0;
  logic bus_start = 0, bus_addr_vld = 0, bus_data_vld = 0, bus_stop = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic ack_vld, ack, wel, rwel, busy, nv_store, trip_set, trip_reset;
  logic [7:0] ctrl_q;

  int n_chk = 0, n_fail = 0;
  logic exp_q[$];
  string req_q[$];

  ctrl_reg_guard #(.WR_CYCLES(WR)) i_ctrl_reg_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && ack_vld) begin
    if (exp_q.size() == 0) chk(0, "R11 unexpected ack_vld", ack, 0);
    else begin
      logic e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(ack == e, r, ack, e);
    end
  end

  task automatic clr();
    bus_start = 0; bus_addr_vld = 0; bus_data_vld = 0; bus_stop = 0;
  endtask

  task automatic xfer(input logic [15:0] a, input logic [7:0] d, input int n,
                      input bit e0, input bit do_stop, input string req);
    @(negedge clk); clr(); bus_start = 1;
    @(negedge clk); clr(); bus_addr_vld = 1; bus_addr = a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clr(); bus_data_vld = 1; bus_data = (i == 0) ? d : 8'hA5;
      exp_q.push_back(i == 0 ? e0 : 1'b0);
      req_q.push_back(i == 0 ? req : "R5 later byte");
    end
    if (do_stop) begin
      @(negedge clk); clr(); bus_stop = 1;
    end
    @(negedge clk); clr();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);
    chk({wel, rwel, busy} == 3'b000, "R1 latches", {wel, rwel, busy}, 0);
    chk({nv_store, trip_set, trip_reset} == 3'b000, "R1 pulses", {nv_store, trip_set, trip_reset}, 0);

    xfer(16'hFFFF, 8'h06, 1, 0, 1, "R3 no wel");
    chk(rwel == 0, "R3 rwel stays", rwel, 0);
    xfer(16'hFFFF, 8'h30, 1, 0, 1, "R4 no unlock");
    chk(ctrl_q == 8'h00, "R4 ctrl unchanged", ctrl_q, 0);

    xfer(16'hFFFF, 8'h02, 1, 1, 1, "R2 wel");
    chk(wel == 1, "R2 wel set", wel, 1);
    chk(ctrl_q == 8'h00, "R2 ctrl unchanged", ctrl_q, 0);

    xfer(16'hFFFF, 8'h06, 0, 0, 1, "R6");
    chk(rwel == 0, "R6 early stop", rwel, 0);
    xfer(16'hFFFF, 8'h06, 1, 1, 0, "R6 abandoned ack");
    xfer(16'h0000, 8'h00, 0, 0, 1, "R6");
    chk(rwel == 0, "R6 abandoned", rwel, 0);

    xfer(16'hFFFF, 8'h06, 1, 1, 1, "R3 rwel");
    chk(rwel == 1, "R3 rwel set", rwel, 1);

    xfer(16'hFFFF, 8'h30, 2, 1, 1, "R4 commit");
    chk(ctrl_q == 8'h30, "R4 R5 ctrl value", ctrl_q, 8'h30);
    chk(nv_store == 1, "R4 store pulse", nv_store, 1);
    chk(rwel == 0 && wel == 1, "R4 latches", {wel, rwel}, 2'b10);
    chk(busy == 1, "R8 busy start", busy, 1);
    @(negedge clk);
    chk(nv_store == 0, "R4 pulse one cycle", nv_store, 0);
    repeat (WR - 2) @(negedge clk);
    chk(busy == 1, "R8 busy last", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R8 busy end", busy, 0);

    hv_prog = 1;
    xfer(16'h0001, 8'h00, 1, 1, 1, "R9 set");
    chk(trip_set == 1 && trip_reset == 0, "R9 set pulse", {trip_set, trip_reset}, 2'b10);
    xfer(16'hFFFF, 8'h06, 1, 0, 1, "R8 nack busy");
    chk(rwel == 0, "R8 no rwel", rwel, 0);
    wait_idle();
    xfer(16'h0003, 8'h00, 1, 1, 1, "R9 reset");
    chk(trip_reset == 1 && trip_set == 0, "R9 reset pulse", {trip_set, trip_reset}, 2'b01);
    wait_idle();
    hv_prog = 0;
    xfer(16'h0001, 8'h00, 1, 0, 1, "R9 no hv");
    chk(trip_set == 0 && busy == 0, "R9 no pulse", {trip_set, busy}, 0);

    xfer(16'h1234, 8'h02, 1, 0, 1, "R11 other addr");

    sys_rst = 1;
    xfer(16'hFFFF, 8'h06, 1, 0, 1, "R10 nack");
    sys_rst = 0;
    chk(rwel == 0, "R10 no rwel", rwel, 0);
    xfer(16'hFFFF, 8'h06, 1, 1, 0, "R10 pre ack");
    sys_rst = 1;
    @(negedge clk); clr(); bus_stop = 1;
    @(negedge clk); clr(); sys_rst = 0;
    chk(rwel == 0, "R10 stop ignored", rwel, 0);

    xfer(16'hFFFF, 8'h06, 1, 1, 1, "R7 unlock");
    xfer(16'hFFFF, 8'h80, 1, 1, 1, "R7 set wpen");
    chk(ctrl_q == 8'h80, "R7 wpen stored", ctrl_q, 8'h80);
    wait_idle();
    wp_pin = 1;
    xfer(16'hFFFF, 8'h06, 1, 0, 1, "R7 locked");
    chk(rwel == 0, "R7 rwel blocked", rwel, 0);
    wp_pin = 0;
    xfer(16'hFFFF, 8'h06, 1, 1, 1, "R7 unlocked");
    chk(rwel == 1, "R7 rwel after unlock", rwel, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all acks seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule